// File: doc/BRIEF.md
# Widening Ordered Floating-Point Sum Reducer

This block reduces a short vector of half-precision values to one single-precision sum. A start pulse captures the whole operand set: the element array, per-element enable bits, a flag that overrides those bits, the active length, a single-precision starting value and a dynamic rounding mode. The unit then walks the element indices from lowest to highest, one index per clock. Every participating element is first converted exactly to single precision and then added into the running sum with one rounded addition.

Exception flags from every step are merged into a sticky set. When the walk ends, a one-cycle done pulse appears together with a write strobe for the single result. The control pins are plain pulses and levels. There is no back-pressure at either edge: the result and flags are held until the next accepted start, and a start that arrives while a reduction is running is dropped.

Top module: `wosum_reducer`

## Requirements
- R1: Each half-precision element is widened to single precision without loss. Subnormal halves become normal singles (0x0001 gives 0x33800000, 0x0200 gives 0x38000000, 0x7BFF gives 0x477FE000), and infinities and zeros keep their sign.
- R2: The running sum is loaded with `init_i` at the accepted start. That value is never counted as one of the vector elements.
- R3: Participating elements are added one at a time in ascending index order, with one rounding per addition. Starting from 2^24 (0x4B800000), adding two elements of 1.0 under nearest-even gives 0x4B800000.
- R4: Only indices below the active length take part. A `vlen_i` above NUM_ELEM is treated as NUM_ELEM.
- R5: When `all_i` is 0, element i takes part only if `mask_i[i]` is 1. When `all_i` is 1, every index below the length takes part and the mask is ignored.
- R6: `rm_i` selects the rounding of every addition: 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero.
- R7: `flags_o` is {invalid, divide-by-zero, overflow, underflow, inexact} in bits 4 down to 0. It is cleared at an accepted start, gathers the flags of every step by OR, and holds its value until the next accepted start.
- R8: A NaN result is always 0x7FC00000. A signaling NaN element or operand raises invalid, and a quiet NaN does not. Adding infinities of opposite sign raises invalid.
- R9: An exact zero sum from operands of opposite sign is +0, except under mode 010, where it is -0.
- R10: An `rm_i` of 101, 110 or 111 at start gives `done_o` together with `illegal_o` one cycle later, and no write strobe.
- R11: An active length of zero gives `done_o` one cycle after the start, with no write strobe.
- R12: `done_o` (and `wr_o` for a reduction that yields a result) is high for one cycle. It appears in the cycle after the L-th rising edge that follows the start edge, where L is the active length. A start while busy is ignored together with its operands, and a start in the done cycle is accepted.
- R13: With a nonzero length and every element masked off, the result equals `init_i`, the flags are zero and `wr_o` is still pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reduction when idle |
| vlen_i | input | $clog2(NUM_ELEM+1) | Active vector length |
| mask_i | input | NUM_ELEM | Per-element enable bits |
| all_i | input | 1 | 1: ignore mask, use every element below the length |
| elems_i | input | 16*NUM_ELEM | Half-precision elements, element i at bits 16i+15:16i |
| init_i | input | 32 | Single-precision starting value |
| rm_i | input | 3 | Dynamic rounding mode |
| result_o | output | 32 | Single-precision sum |
| flags_o | output | 5 | Sticky exception flags |
| wr_o | output | 1 | One-cycle result write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Pulses with done for an unsupported rounding mode |

## Verification
Two events can fall in the same cycle: the accumulation of the last element (which raises done and the write strobe on the next edge) and a new start request. The bench holds start high during the final busy cycle with different operands. It then presents a second start in the done cycle itself. The scoreboard expects one completion per accepted start with exact latency, and a first result untouched by the dropped operands. Any extra done pulse is reported as a failure.

// File: rtl/wosr_pkg.sv
package wosr_pkg;
  localparam int HW = 16;
  localparam int SW = 32;
  localparam int FW = 5;

  localparam int FLG_NV = 4;
  localparam int FLG_DZ = 3;
  localparam int FLG_OF = 2;
  localparam int FLG_UF = 1;
  localparam int FLG_NX = 0;

  localparam logic [2:0] RM_RNE = 3'd0;
  localparam logic [2:0] RM_RTZ = 3'd1;
  localparam logic [2:0] RM_RDN = 3'd2;
  localparam logic [2:0] RM_RUP = 3'd3;
  localparam logic [2:0] RM_RMM = 3'd4;

  localparam logic [SW-1:0] QNAN_S = 32'h7FC0_0000;

  typedef enum logic {ST_IDLE, ST_RUN} red_st_e;
endpackage

// File: rtl/wosr_h2s.sv
module wosr_h2s
  import wosr_pkg::*;
(
  input  logic [HW-1:0] h_i,
  output logic [SW-1:0] s_o,
  output logic          snan_o
);
  logic       sgn;
  logic [4:0] hexp;
  logic [9:0] hfrac;
  logic [3:0] lead;
  logic [7:0] sexp;
  logic [23:0] mant;

  assign sgn   = h_i[15];
  assign hexp  = h_i[14:10];
  assign hfrac = h_i[9:0];

  // position of the highest set fraction bit, used for subnormal halves
  always_comb begin
    lead = '0;
    for (int i = 0; i < 10; i++) begin
      if (hfrac[i]) lead = 4'(i);
    end
  end

  always_comb begin
    snan_o = 1'b0;
    sexp   = '0;
    mant   = '0;
    s_o    = '0;
    if (hexp == 5'h1F) begin
      if (hfrac == '0) begin
        s_o = {sgn, 8'hFF, 23'd0};
      end else begin
        s_o    = QNAN_S;
        snan_o = ~hfrac[9];
      end
    end else if (hexp == 5'd0) begin
      if (hfrac == '0) begin
        s_o = {sgn, 31'd0};
      end else begin
        sexp = 8'd103 + {4'd0, lead};
        mant = {14'd0, hfrac} << (5'd23 - {1'b0, lead});
        s_o  = {sgn, sexp, mant[22:0]};
      end
    end else begin
      sexp = {3'd0, hexp} + 8'd112;
      s_o  = {sgn, sexp, hfrac, 13'd0};
    end
  end
endmodule

// File: rtl/wosr_add32.sv
module wosr_add32
  import wosr_pkg::*;
(
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic [2:0]    rm_i,
  output logic [SW-1:0] sum_o,
  output logic [FW-1:0] flg_o
);
  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf;
  logic swap, sub, sgn, inc, g, st, inx, to_inf;
  logic [SW-1:0] big, sml;
  logic [7:0]  eb, es, ebx, esx, dd, lz, lim, sh;
  logic [23:0] mb, ms;
  logic [53:0] tmp;
  logic [26:0] al, nm;
  logic [27:0] ma, raw;
  logic [4:0]  p;
  logic [9:0]  en, ef;
  logic [24:0] rr;

  assign a_nan  = (a_i[30:23] == 8'hFF) && (a_i[22:0] != '0);
  assign b_nan  = (b_i[30:23] == 8'hFF) && (b_i[22:0] != '0);
  assign a_snan = a_nan && !a_i[22];
  assign b_snan = b_nan && !b_i[22];
  assign a_inf  = (a_i[30:23] == 8'hFF) && (a_i[22:0] == '0);
  assign b_inf  = (b_i[30:23] == 8'hFF) && (b_i[22:0] == '0);

  // operand ordering by magnitude so the difference is never negative
  assign swap = b_i[30:0] > a_i[30:0];
  assign big  = swap ? b_i : a_i;
  assign sml  = swap ? a_i : b_i;
  assign eb   = big[30:23];
  assign es   = sml[30:23];
  assign mb   = {|eb, big[22:0]};
  assign ms   = {|es, sml[22:0]};
  assign ebx  = (eb == '0) ? 8'd1 : eb;
  assign esx  = (es == '0) ? 8'd1 : es;
  assign dd   = ebx - esx;
  assign sub  = big[31] ^ sml[31];
  assign ma   = {1'b0, mb, 3'b000};

  // alignment with guard, round and sticky bits
  always_comb begin
    tmp = {ms, 30'd0} >> dd;
    if (dd > 8'd26) al = {26'd0, |ms};
    else            al = tmp[53:27] | {26'd0, |tmp[26:0]};
    raw = sub ? (ma - {1'b0, al}) : (ma + {1'b0, al});
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < 28; i++) begin
      if (raw[i]) p = 5'(i);
    end
  end

  // normalisation, never shifting below the smallest normal exponent
  always_comb begin
    lz  = 8'd26 - {3'd0, p};
    lim = ebx - 8'd1;
    sh  = '0;
    if (raw[27]) begin
      nm = {raw[27:2], raw[1] | raw[0]};
      en = {2'd0, ebx} + 10'd1;
    end else begin
      sh = (lz < lim) ? lz : lim;
      nm = raw[26:0] << sh;
      en = {2'd0, ebx} - {2'd0, sh};
    end
  end

  // rounding
  always_comb begin
    sgn = big[31];
    g   = nm[2];
    st  = |nm[1:0];
    inx = g | st;
    case (rm_i)
      RM_RNE:  inc = g & (st | nm[3]);
      RM_RTZ:  inc = 1'b0;
      RM_RDN:  inc = inx & sgn;
      RM_RUP:  inc = inx & ~sgn;
      default: inc = g;
    endcase
    rr = {1'b0, nm[26:3]} + {24'd0, inc};
    if (rr[24]) ef = en + 10'd1;
    else        ef = rr[23] ? en : 10'd0;
    case (rm_i)
      RM_RTZ:  to_inf = 1'b0;
      RM_RDN:  to_inf = sgn;
      RM_RUP:  to_inf = ~sgn;
      default: to_inf = 1'b1;
    endcase
  end

  always_comb begin
    flg_o = '0;
    sum_o = '0;
    if (a_nan || b_nan) begin
      sum_o         = QNAN_S;
      flg_o[FLG_NV] = a_snan | b_snan;
    end else if (a_inf && b_inf && (a_i[31] != b_i[31])) begin
      sum_o         = QNAN_S;
      flg_o[FLG_NV] = 1'b1;
    end else if (a_inf) begin
      sum_o = a_i;
    end else if (b_inf) begin
      sum_o = b_i;
    end else if (raw == '0) begin
      sum_o = {sub ? (rm_i == RM_RDN) : sgn, 31'd0};
    end else if (ef >= 10'd255) begin
      sum_o         = to_inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
      flg_o[FLG_OF] = 1'b1;
      flg_o[FLG_NX] = 1'b1;
    end else begin
      sum_o         = {sgn, ef[7:0], rr[24] ? 23'd0 : rr[22:0]};
      flg_o[FLG_NX] = inx;
      flg_o[FLG_UF] = inx & (ef == '0);
    end
  end
endmodule

// File: rtl/wosr_pick.sv
module wosr_pick
  import wosr_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic [NUM_ELEM*HW-1:0] elems_i,
  input  logic [NUM_ELEM-1:0]    mask_i,
  input  logic                   all_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [HW-1:0]          elem_o,
  output logic                   act_o
);
  logic [HW-1:0] lane [NUM_ELEM];
  logic [NUM_ELEM-1:0] use_v;

  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_lane
    assign lane[gi]  = elems_i[gi*HW +: HW];
    assign use_v[gi] = all_i | mask_i[gi];
  end

  assign elem_o = lane[idx_i];
  assign act_o  = use_v[idx_i];
endmodule

// File: rtl/wosum_reducer.sv
module wosum_reducer
  import wosr_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  localparam int VL_W  = $clog2(NUM_ELEM + 1),
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [VL_W-1:0]        vlen_i,
  input  logic [NUM_ELEM-1:0]    mask_i,
  input  logic                   all_i,
  input  logic [NUM_ELEM*HW-1:0] elems_i,
  input  logic [SW-1:0]          init_i,
  input  logic [2:0]             rm_i,
  output logic [SW-1:0]          result_o,
  output logic [FW-1:0]          flags_o,
  output logic                   wr_o,
  output logic                   done_o,
  output logic                   illegal_o
);
  red_st_e st;
  logic [SW-1:0]          acc;
  logic [FW-1:0]          flg;
  logic [IDX_W-1:0]       idx;
  logic [VL_W-1:0]        vl_r, vl_eff;
  logic [2:0]             rm_r;
  logic [NUM_ELEM-1:0]    msk_r;
  logic                   all_r;
  logic [NUM_ELEM*HW-1:0] el_r;
  logic                   done_q, wr_q, ill_q;
  logic                   busy, rm_ok, last, act, wsnan;
  logic [HW-1:0]          cur_h;
  logic [SW-1:0]          cur_s, sum;
  logic [FW-1:0]          add_f, step_f;

  assign busy   = (st == ST_RUN);
  assign rm_ok  = (rm_i <= RM_RMM);
  assign vl_eff = (vlen_i > VL_W'(NUM_ELEM)) ? VL_W'(NUM_ELEM) : vlen_i;
  assign last   = (VL_W'(idx) + VL_W'(1)) == vl_r;

  wosr_pick #(.NUM_ELEM(NUM_ELEM)) u_pick (
    .elems_i (el_r),
    .mask_i  (msk_r),
    .all_i   (all_r),
    .idx_i   (idx),
    .elem_o  (cur_h),
    .act_o   (act)
  );

  wosr_h2s u_h2s (
    .h_i    (cur_h),
    .s_o    (cur_s),
    .snan_o (wsnan)
  );

  wosr_add32 u_add (
    .a_i   (acc),
    .b_i   (cur_s),
    .rm_i  (rm_r),
    .sum_o (sum),
    .flg_o (add_f)
  );

  assign step_f = add_f | {wsnan, {(FW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      acc    <= '0;
      flg    <= '0;
      idx    <= '0;
      vl_r   <= '0;
      rm_r   <= '0;
      msk_r  <= '0;
      all_r  <= 1'b0;
      el_r   <= '0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      ill_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            acc   <= init_i;
            flg   <= '0;
            idx   <= '0;
            vl_r  <= vl_eff;
            rm_r  <= rm_i;
            msk_r <= mask_i;
            all_r <= all_i;
            el_r  <= elems_i;
            if (!rm_ok) begin
              done_q <= 1'b1;
              ill_q  <= 1'b1;
            end else if (vl_eff == '0) begin
              done_q <= 1'b1;
            end else begin
              st <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (act) begin
            acc <= sum;
            flg <= flg | step_f;
          end
          idx <= idx + IDX_W'(1);
          if (last) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            wr_q   <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign result_o  = acc;
  assign flags_o   = flg;
  assign wr_o      = wr_q;
  assign done_o    = done_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/wosr_chk.sv
module wosr_chk #(
  parameter int VL_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [VL_W-1:0] vlen_i,
  input logic [2:0]      rm_i,
  input logic            busy,
  input logic [31:0]     result_o,
  input logic [4:0]      flags_o,
  input logic            wr_o,
  input logic            done_o,
  input logic            illegal_o
);
  assert_wr_needs_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (done_o && !illegal_o));

  assert_bad_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && rm_i > 3'd4) |=> (done_o && illegal_o && !wr_o));

  assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && rm_i <= 3'd4 && vlen_i == '0) |=> (done_o && !wr_o && !illegal_o));

  assert_run_starts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && rm_i <= 3'd4 && vlen_i != '0) |=> (busy && !done_o));

  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> (flags_o == 5'd0));

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_result_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(result_o));

  assert_nan_canon_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && result_o[30:23] == 8'hFF && result_o[22:0] != '0) |-> (result_o == 32'h7FC0_0000));
endmodule

bind wosum_reducer wosr_chk #(.VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .vlen_i    (vlen_i),
  .rm_i      (rm_i),
  .busy      (busy),
  .result_o  (result_o),
  .flags_o   (flags_o),
  .wr_o      (wr_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/wosum_reducer_tb.sv
module wosum_reducer_tb;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    vlen_i = '0;
  logic [NE-1:0] mask_i = '0;
  logic          all_i = 1'b0;
  logic [NE*16-1:0] elems_i = '0;
  logic [31:0]   init_i = '0;
  logic [2:0]    rm_i = '0;
  logic [31:0]   result_o;
  logic [4:0]    flags_o;
  logic          wr_o, done_o, illegal_o;

  always #5 clk = ~clk;

  wosum_reducer #(.NUM_ELEM(NE)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .vlen_i (vlen_i),
    .mask_i (mask_i), .all_i (all_i), .elems_i (elems_i), .init_i (init_i),
    .rm_i (rm_i), .result_o (result_o), .flags_o (flags_o), .wr_o (wr_o),
    .done_o (done_o), .illegal_o (illegal_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int lat, elat;
  logic [31:0] er;
  logic [4:0]  ef;
  logic        ew, ei;
  string       et;

  logic [31:0] q_res [$];
  logic [4:0]  q_flg [$];
  logic        q_wr  [$];
  logic        q_ill [$];
  int          q_lat [$];
  int          q_s   [$];
  string       q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NE*16-1:0] el4(input logic [15:0] a, b, c, d);
    return {64'h0, d, c, b, a};
  endfunction

  task automatic push_exp(input logic [31:0] r, input logic [4:0] f, input logic w,
                          input logic il, input int l, input string tag);
    q_res.push_back(r); q_flg.push_back(f); q_wr.push_back(w);
    q_ill.push_back(il); q_lat.push_back(l); q_s.push_back(cyc); q_tag.push_back(tag);
  endtask

  task automatic drive(input logic [3:0] vl, input logic [7:0] msk, input logic al,
                       input logic [NE*16-1:0] el, input logic [31:0] ini, input logic [2:0] rm);
    vlen_i = vl; mask_i = msk; all_i = al; elems_i = el; init_i = ini; rm_i = rm;
    start_i = 1'b1;
  endtask

  task automatic run(input logic [3:0] vl, input logic [7:0] msk, input logic al,
                     input logic [NE*16-1:0] el, input logic [31:0] ini, input logic [2:0] rm,
                     input logic [31:0] r, input logic [4:0] f, input logic w, input logic il,
                     input string tag);
    int vle;
    @(negedge clk);
    drive(vl, msk, al, el, ini, rm);
    vle = (vl > 4'd8) ? 8 : int'(vl);
    push_exp(r, f, w, il, (il || vle == 0) ? 1 : vle + 1, tag);
    @(negedge clk);
    start_i = 1'b0;
    while (q_res.size() != 0) @(negedge clk);
  endtask

  // monitor: compares each completion against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q_res.size() == 0) begin
        chk(1'b0, "R12", "unexpected done", 32'd1, 32'd0);
      end else begin
        er = q_res.pop_front(); ef = q_flg.pop_front(); ew = q_wr.pop_front();
        ei = q_ill.pop_front(); elat = q_lat.pop_front(); et = q_tag.pop_front();
        lat = cyc - q_s.pop_front();
        chk(lat == elat, et, "latency R12", 32'(lat), 32'(elat));
        chk(wr_o == ew, et, "write strobe", {31'd0, wr_o}, {31'd0, ew});
        chk(illegal_o == ei, et, "illegal", {31'd0, illegal_o}, {31'd0, ei});
        chk(flags_o == ef, et, "flags", {27'd0, flags_o}, {27'd0, ef});
        if (ew) chk(result_o == er, et, "result", result_o, er);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !wr_o && !illegal_o, "R12", "reset strobes",
        {29'd0, done_o, wr_o, illegal_o}, 32'd0);
    chk(flags_o == 5'd0, "R7", "reset flags", {27'd0, flags_o}, 32'd0);
    chk(result_o == 32'd0, "R2", "reset result", result_o, 32'd0);

    // R5 masking: elements 0 and 2 only -> 1+3
    run(4'd4, 8'b0101, 1'b0, el4(16'h3C00, 16'h4000, 16'h4200, 16'h4400), 32'h0, 3'd0,
        32'h4080_0000, 5'h00, 1'b1, 1'b0, "R5 masked");
    // R5 mask ignored -> 10
    run(4'd4, 8'b0101, 1'b1, el4(16'h3C00, 16'h4000, 16'h4200, 16'h4400), 32'h0, 3'd0,
        32'h4120_0000, 5'h00, 1'b1, 1'b0, "R5 all");
    // R4 length 3 -> 6
    run(4'd3, 8'b0000, 1'b1, el4(16'h3C00, 16'h4000, 16'h4200, 16'h4400), 32'h0, 3'd0,
        32'h40C0_0000, 5'h00, 1'b1, 1'b0, "R4 length");
    // R4 oversize length clamps to 8 elements
    run(4'd15, 8'b0000, 1'b1, {8{16'h3C00}}, 32'h0, 3'd0,
        32'h4100_0000, 5'h00, 1'b1, 1'b0, "R4 clamp");
    // R13 and R2: all masked returns init
    run(4'd4, 8'b0000, 1'b0, el4(16'h3C00, 16'h4000, 16'h4200, 16'h4400), 32'h4040_0000, 3'd0,
        32'h4040_0000, 5'h00, 1'b1, 1'b0, "R13 R2 all masked");
    // R3 ordered path
    run(4'd2, 8'b0000, 1'b1, el4(16'h3C00, 16'h3C00, 16'h0, 16'h0), 32'h4B80_0000, 3'd0,
        32'h4B80_0000, 5'h01, 1'b1, 1'b0, "R3 ordered");
    // R6 rounding modes on a tie
    run(4'd1, 8'b0, 1'b1, el4(16'h3C00, 0, 0, 0), 32'h4B80_0000, 3'd1, 32'h4B80_0000, 5'h01, 1'b1, 1'b0, "R6 rtz");
    run(4'd1, 8'b0, 1'b1, el4(16'h3C00, 0, 0, 0), 32'h4B80_0000, 3'd2, 32'h4B80_0000, 5'h01, 1'b1, 1'b0, "R6 rdn");
    run(4'd1, 8'b0, 1'b1, el4(16'h3C00, 0, 0, 0), 32'h4B80_0000, 3'd3, 32'h4B80_0001, 5'h01, 1'b1, 1'b0, "R6 rup");
    run(4'd1, 8'b0, 1'b1, el4(16'h3C00, 0, 0, 0), 32'h4B80_0000, 3'd4, 32'h4B80_0001, 5'h01, 1'b1, 1'b0, "R6 rmm");
    run(4'd1, 8'b0, 1'b1, el4(16'hBC00, 0, 0, 0), 32'hCB80_0000, 3'd2, 32'hCB80_0001, 5'h01, 1'b1, 1'b0, "R6 rdn neg");
    run(4'd1, 8'b0, 1'b1, el4(16'hBC00, 0, 0, 0), 32'hCB80_0000, 3'd3, 32'hCB80_0000, 5'h01, 1'b1, 1'b0, "R6 rup neg");
    // R9 exact zero sign
    run(4'd1, 8'b0, 1'b1, el4(16'hBC00, 0, 0, 0), 32'h3F80_0000, 3'd0, 32'h0000_0000, 5'h00, 1'b1, 1'b0, "R9 rne zero");
    run(4'd1, 8'b0, 1'b1, el4(16'hBC00, 0, 0, 0), 32'h3F80_0000, 3'd2, 32'h8000_0000, 5'h00, 1'b1, 1'b0, "R9 rdn zero");
    // R8 NaN handling
    run(4'd1, 8'b0, 1'b1, el4(16'hFC00, 0, 0, 0), 32'h7F80_0000, 3'd0, 32'h7FC0_0000, 5'h10, 1'b1, 1'b0, "R8 inf minus inf");
    run(4'd1, 8'b0, 1'b1, el4(16'h7C01, 0, 0, 0), 32'h0, 3'd0, 32'h7FC0_0000, 5'h10, 1'b1, 1'b0, "R8 snan");
    run(4'd1, 8'b0, 1'b1, el4(16'h7E00, 0, 0, 0), 32'h0, 3'd0, 32'h7FC0_0000, 5'h00, 1'b1, 1'b0, "R8 qnan");
    // R1 exact widening
    run(4'd2, 8'b0, 1'b1, el4(16'h0001, 16'h0200, 0, 0), 32'h0, 3'd0, 32'h3800_4000, 5'h00, 1'b1, 1'b0, "R1 subnormal");
    run(4'd1, 8'b0, 1'b1, el4(16'h0001, 0, 0, 0), 32'h0, 3'd0, 32'h3380_0000, 5'h00, 1'b1, 1'b0, "R1 tiny");
    run(4'd1, 8'b0, 1'b1, el4(16'h7BFF, 0, 0, 0), 32'h0, 3'd0, 32'h477F_E000, 5'h00, 1'b1, 1'b0, "R1 max");
    run(4'd1, 8'b0, 1'b1, el4(16'hFC00, 0, 0, 0), 32'h0, 3'd0, 32'hFF80_0000, 5'h00, 1'b1, 1'b0, "R1 neg inf");
    run(4'd1, 8'b0, 1'b1, el4(16'h8000, 0, 0, 0), 32'h8000_0000, 3'd0, 32'h8000_0000, 5'h00, 1'b1, 1'b0, "R1 neg zero");
    // R7 sticky flags across steps
    run(4'd2, 8'b0, 1'b1, el4(16'h3C00, 16'h7C01, 0, 0), 32'h4B80_0000, 3'd0, 32'h7FC0_0000, 5'h11, 1'b1, 1'b0, "R7 sticky");
    run(4'd1, 8'b0, 1'b1, el4(16'h4000, 0, 0, 0), 32'h3F80_0000, 3'd0, 32'h4040_0000, 5'h00, 1'b1, 1'b0, "R7 cleared");
    // R10 unsupported modes
    run(4'd2, 8'b0, 1'b1, el4(16'h3C00, 16'h3C00, 0, 0), 32'h0, 3'd5, 32'h0, 5'h00, 1'b0, 1'b1, "R10 mode5");
    run(4'd2, 8'b0, 1'b1, el4(16'h3C00, 16'h3C00, 0, 0), 32'h0, 3'd7, 32'h0, 5'h00, 1'b0, 1'b1, "R10 mode7");
    // R11 zero length
    run(4'd0, 8'b0, 1'b1, el4(16'h3C00, 0, 0, 0), 32'h4000_0000, 3'd0, 32'h0, 5'h00, 1'b0, 1'b0, "R11 empty");

    // R12 start during the final step is dropped, start in done cycle is taken
    @(negedge clk);
    drive(4'd4, 8'b0, 1'b1, el4(16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00), 32'h0, 3'd0);
    push_exp(32'h4080_0000, 5'h00, 1'b1, 1'b0, 5, "R12 busy first");
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    drive(4'd1, 8'b0, 1'b1, {8{16'h7C01}}, 32'h7F80_0000, 3'd0);
    @(negedge clk);
    drive(4'd1, 8'b0, 1'b1, el4(16'h4000, 0, 0, 0), 32'h3F80_0000, 3'd0);
    push_exp(32'h4040_0000, 5'h00, 1'b1, 1'b0, 2, "R12 back to back");
    @(negedge clk);
    start_i = 1'b0;
    while (q_res.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q_res.size() == 0, "R12", "pending expectations", 32'(q_res.size()), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule